// File: doc/BRIEF.md
# Multi-Area Synchronous Host Bus Front End

This block sits at the edge of a memory subsystem. It terminates a 16-bit host bus with word addressing, five active-low enables, an address strobe, read and write strobes, two byte selects and a clock for synchronous mode. Each host access is steered to one of five internal areas: a boot flash area, a fast cached flash area, a slower cached flash area, a RAM area and a disk-style register area. Every area has its own valid/ready request port. The ready inputs and the address bus are shared, and each area also has its own read-data lane.

In synchronous mode, an edge with the address strobe low and a mapped enable active captures the address, the area and the direction. The block then waits out that area's initial latency, which differs between read and write. After that it moves one word on every cycle in which the area reports ready, advancing the word address on each beat. The WAIT output is active while data cannot move, and its polarity is selectable. In asynchronous mode the strobes pass straight through to the selected area. WAIT has meaning there only for the three areas behind the shared enable.

Top module: `hostbus_front`

## Requirements
- R1: Enable decode uses `bus_ce_n[0]` for the boot area (area code 0), `bus_ce_n[1]` for the shared group (codes 1 to 3) and `bus_ce_n[4]` for the disk area (code 4). Enables 2 and 3 select nothing. When more than one is low, the priority is 0, then 1, then 4. At most one bit of `req_valid` is high at any time, and bit k belongs to area code k.
- R2: Within the shared group, a captured word address below the low bound selects the fast area (1). An address below the high bound selects the slow area (2). Any other address selects RAM (3). Both bounds are sampled only while `rst_n` is low.
- R3: Suppose the address strobe is low and a mapped enable is active at edge E0. Then the area's `req_valid` first rises in the cycle that follows edge E0+L-1, so the first word moves at edge E0+L. L is (read/write): boot 4/3, fast 4/3, slow 10/7, RAM 9/6, disk 3/3. The direction is write when `bus_we_n` is low at E0. Read data on `bus_rdata` is the selected area's lane.
- R4: In synchronous mode, WAIT is active from the cycle after E0 until a data cycle in which the area is ready. It is inactive in any cycle where `req_valid` and the matching `req_ready` are both high. It is active again in any data cycle where ready is low.
- R5: When `wait_pol` is 1, an active WAIT is high. When `wait_pol` is 0, an active WAIT is low.
- R6: Areas 1 to 3 burst. `req_addr` rises by one after each moved word. The burst ends, and the block returns to idle, after 32 words.
- R7: Areas 0 and 4 do single accesses. The cycle after their one word, `req_valid` is low even if the enable stays low.
- R8: If the captured area's enable goes high during latency or data, `req_valid` drops in that same cycle and WAIT goes inactive. The block is idle from the next edge, and no further word moves until a new address strobe arrives.
- R9: In asynchronous mode (`sync_en` = 0), `req_valid` for the decoded area is high while its enable is low and either read or write strobe is low, and `req_addr` follows `bus_addr`. WAIT is inactive for areas 0 and 4. For areas 1 to 3 it is active while valid is high and ready is low.
- R10: `req_be` is {~`bus_ub_n`, ~`bus_lb_n`} (bit 1 = upper byte). `req_wdata` follows `bus_wdata`.
- R11: During and right after reset, `req_valid` is all zero and WAIT is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | 1 = synchronous mode, 0 = strobe pass-through |
| wait_pol | input | 1 | 1 = WAIT active high |
| cfg_bound_lo | input | 26 | Fast/slow split, sampled in reset |
| cfg_bound_hi | input | 26 | Slow/RAM split, sampled in reset |
| bus_ce_n | input | 5 | Active-low enables |
| bus_adv_n | input | 1 | Address strobe, active low |
| bus_oe_n | input | 1 | Read strobe, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_ub_n | input | 1 | Upper byte select, active low |
| bus_lb_n | input | 1 | Lower byte select, active low |
| bus_addr | input | 26 | Word address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data to host |
| bus_wait | output | 1 | WAIT to host |
| req_valid | output | 5 | Per-area request valid |
| req_write | output | 1 | Request is a write |
| req_addr | output | 26 | Request word address |
| req_wdata | output | 16 | Request write data |
| req_be | output | 2 | Byte enables |
| req_ready | input | 5 | Per-area ready |
| area_rdata | input | 80 | Per-area read data, lane k at bits 16k+15:16k |

## Verification
Two events can land in the same data cycle: a word transfer and the loss of the enable that ends a burst. The bench releases the enable in a cycle where the area's ready is high. The enable must win: `req_valid` must be low in that cycle, WAIT must be inactive, and no word may move once the enable is driven low again without a new address strobe. A ready stall inside a burst is also placed right before further beats. It must hold the address and keep WAIT active without dropping the transfer.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
package hbf_pkg;
    localparam int unsigned N_AREA = 5;

    typedef enum logic [2:0] {
        AREA_BOOT   = 3'd0,
        AREA_FAST   = 3'd1,
        AREA_PSEUDO = 3'd2,
        AREA_RAM    = 3'd3,
        AREA_DISK   = 3'd4
    } area_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAT  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    function automatic logic burst_ok(area_e a);
        return (a == AREA_FAST) || (a == AREA_PSEUDO) || (a == AREA_RAM);
    endfunction
endpackage

// File: rtl/hbf_area_decode.sv
`timescale 1ns/1ps
module hbf_area_decode
    import hbf_pkg::*;
#(
    parameter int unsigned AW        = 26,
    parameter int unsigned NCE       = 5,
    parameter int unsigned CE_BOOT   = 0,
    parameter int unsigned CE_SHARED = 1,
    parameter int unsigned CE_DISK   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_bound_lo,
    input  logic [AW-1:0]     cfg_bound_hi,
    input  logic [NCE-1:0]    ce_n,
    input  logic [AW-1:0]     addr,
    output area_e             area,
    output logic              hit,
    output logic [N_AREA-1:0] area_en
);
    localparam logic [NCE-1:0] MAPPED =
        NCE'((1 << CE_BOOT) | (1 << CE_SHARED) | (1 << CE_DISK));

    typedef struct packed {
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } bound_t;

    bound_t bnd_d, bnd_q;
    area_e  shared_area;
    logic   unused_ce;

    // bounds follow the inputs only while reset is held
    always_comb begin
        bnd_d = bnd_q;
        if (!rst_n) begin
            bnd_d.lo = cfg_bound_lo;
            bnd_d.hi = cfg_bound_hi;
        end
    end

    always_ff @(posedge clk) begin
        bnd_q <= bnd_d;
    end

    always_comb begin
        if (addr < bnd_q.lo)      shared_area = AREA_FAST;
        else if (addr < bnd_q.hi) shared_area = AREA_PSEUDO;
        else                      shared_area = AREA_RAM;

        hit = !ce_n[CE_BOOT] || !ce_n[CE_SHARED] || !ce_n[CE_DISK];
        if (!ce_n[CE_BOOT])        area = AREA_BOOT;
        else if (!ce_n[CE_SHARED]) area = shared_area;
        else                       area = AREA_DISK;

        area_en              = '0;
        area_en[AREA_BOOT]   = !ce_n[CE_BOOT];
        area_en[AREA_FAST]   = !ce_n[CE_SHARED];
        area_en[AREA_PSEUDO] = !ce_n[CE_SHARED];
        area_en[AREA_RAM]    = !ce_n[CE_SHARED];
        area_en[AREA_DISK]   = !ce_n[CE_DISK];
    end

    // enables that must be held high take no part in the decode
    assign unused_ce = ^(ce_n & ~MAPPED);
endmodule

// File: rtl/hbf_burst_seq.sv
`timescale 1ns/1ps
module hbf_burst_seq
    import hbf_pkg::*;
#(
    parameter int unsigned AW        = 26,
    parameter int unsigned LAT_CW    = 4,
    parameter int unsigned MAX_BURST = 32,
    parameter int unsigned LAT_RD [N_AREA] = '{4, 4, 10, 9, 3},
    parameter int unsigned LAT_WR [N_AREA] = '{3, 3, 7, 6, 3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              hit,
    input  area_e             area_now,
    input  logic [AW-1:0]     addr,
    input  logic [N_AREA-1:0] area_en,
    input  logic [N_AREA-1:0] ready_in,
    output phase_e            phase,
    output area_e             area_q,
    output logic [AW-1:0]     addr_q,
    output logic              wr_q,
    output logic              live
);
    localparam int unsigned BW = $clog2(MAX_BURST + 1);

    typedef struct packed {
        phase_e            ph;
        logic [LAT_CW-1:0] cnt;
        logic [BW-1:0]     beats;
        logic [AW-1:0]     addr;
        area_e             area;
        logic              wr;
    } seq_t;

    seq_t s_d, s_q;
    logic rdy;

    assign live = area_en[s_q.area];
    assign rdy  = ready_in[s_q.area];

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (sync_en && !adv_n && hit) begin
                    s_d.ph    = PH_LAT;
                    s_d.area  = area_now;
                    s_d.wr    = !we_n;
                    s_d.addr  = addr;
                    s_d.beats = '0;
                    s_d.cnt   = LAT_CW'((!we_n ? LAT_WR[area_now]
                                               : LAT_RD[area_now]) - 2);
                end
            end
            PH_LAT: begin
                if (!live)              s_d.ph  = PH_IDLE;
                else if (s_q.cnt == '0) s_d.ph  = PH_DATA;
                else                    s_d.cnt = s_q.cnt - 1'b1;
            end
            PH_DATA: begin
                if (!live) begin
                    s_d.ph = PH_IDLE;
                end else if (rdy) begin
                    s_d.addr  = s_q.addr + 1'b1;
                    s_d.beats = s_q.beats + 1'b1;
                    if (!burst_ok(s_q.area) || s_q.beats == BW'(MAX_BURST - 1))
                        s_d.ph = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase  = s_q.ph;
    assign area_q = s_q.area;
    assign addr_q = s_q.addr;
    assign wr_q   = s_q.wr;
endmodule

// File: rtl/hbf_wait_gen.sv
`timescale 1ns/1ps
module hbf_wait_gen
    import hbf_pkg::*;
(
    input  logic   sync_en,
    input  logic   wait_pol,
    input  phase_e phase,
    input  logic   live,
    input  logic   ready_sel,
    input  logic   async_shared_req,
    input  logic   async_ready,
    output logic   bus_wait
);
    logic act;

    always_comb begin
        if (sync_en)
            act = live && ((phase == PH_LAT) || (phase == PH_DATA && !ready_sel));
        else
            act = async_shared_req && !async_ready;
        bus_wait = wait_pol ? act : !act;
    end
endmodule

// File: rtl/hostbus_front.sv
`timescale 1ns/1ps
module hostbus_front
    import hbf_pkg::*;
#(
    parameter int unsigned AW        = 26,
    parameter int unsigned DW        = 16,
    parameter int unsigned NCE       = 5,
    parameter int unsigned CE_BOOT   = 0,
    parameter int unsigned CE_SHARED = 1,
    parameter int unsigned CE_DISK   = 4,
    parameter int unsigned MAX_BURST = 32,
    parameter int unsigned LAT_CW    = 4,
    parameter int unsigned LAT_RD [N_AREA] = '{4, 4, 10, 9, 3},
    parameter int unsigned LAT_WR [N_AREA] = '{3, 3, 7, 6, 3}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_en,
    input  logic                 wait_pol,
    input  logic [AW-1:0]        cfg_bound_lo,
    input  logic [AW-1:0]        cfg_bound_hi,
    input  logic [NCE-1:0]       bus_ce_n,
    input  logic                 bus_adv_n,
    input  logic                 bus_oe_n,
    input  logic                 bus_we_n,
    input  logic                 bus_ub_n,
    input  logic                 bus_lb_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_wait,
    output logic [N_AREA-1:0]    req_valid,
    output logic                 req_write,
    output logic [AW-1:0]        req_addr,
    output logic [DW-1:0]        req_wdata,
    output logic [1:0]           req_be,
    input  logic [N_AREA-1:0]    req_ready,
    input  logic [N_AREA*DW-1:0] area_rdata
);
    area_e             area_now, area_q, sel_area;
    logic              hit, live, wr_q, strobe, async_shared;
    logic [N_AREA-1:0] area_en;
    logic [AW-1:0]     addr_q;
    phase_e            phase;

    hbf_area_decode #(
        .AW(AW), .NCE(NCE), .CE_BOOT(CE_BOOT),
        .CE_SHARED(CE_SHARED), .CE_DISK(CE_DISK)
    ) dec_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_bound_lo(cfg_bound_lo), .cfg_bound_hi(cfg_bound_hi),
        .ce_n(bus_ce_n), .addr(bus_addr),
        .area(area_now), .hit(hit), .area_en(area_en)
    );

    hbf_burst_seq #(
        .AW(AW), .LAT_CW(LAT_CW), .MAX_BURST(MAX_BURST),
        .LAT_RD(LAT_RD), .LAT_WR(LAT_WR)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .adv_n(bus_adv_n), .we_n(bus_we_n), .hit(hit),
        .area_now(area_now), .addr(bus_addr), .area_en(area_en),
        .ready_in(req_ready), .phase(phase), .area_q(area_q),
        .addr_q(addr_q), .wr_q(wr_q), .live(live)
    );

    assign strobe       = !bus_oe_n || !bus_we_n;
    assign sel_area     = sync_en ? area_q : area_now;
    assign async_shared = hit && strobe && burst_ok(area_now);

    hbf_wait_gen wait_i (
        .sync_en(sync_en), .wait_pol(wait_pol), .phase(phase),
        .live(live), .ready_sel(req_ready[area_q]),
        .async_shared_req(async_shared), .async_ready(req_ready[area_now]),
        .bus_wait(bus_wait)
    );

    for (genvar a = 0; a < N_AREA; a++) begin : g_valid
        assign req_valid[a] = (sel_area == area_e'(a)) &&
                              (sync_en ? (phase == PH_DATA && live)
                                       : (hit && strobe));
    end

    assign req_write = sync_en ? wr_q : !bus_we_n;
    assign req_addr  = sync_en ? addr_q : bus_addr;
    assign req_wdata = bus_wdata;
    assign req_be    = {!bus_ub_n, !bus_lb_n};
    assign bus_rdata = area_rdata[int'(sel_area)*DW +: DW];
endmodule

// File: rtl/hbf_checker.sv
`timescale 1ns/1ps
module hbf_checker #(
    parameter int unsigned AW = 26,
    parameter int unsigned NA = 5,
    parameter int unsigned NCE = 5,
    parameter int unsigned CE_BOOT = 0,
    parameter int unsigned CE_SHARED = 1,
    parameter int unsigned CE_DISK = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sync_en,
    input logic           wait_pol,
    input logic [NCE-1:0] bus_ce_n,
    input logic           bus_wait,
    input logic [NA-1:0]  req_valid,
    input logic [NA-1:0]  req_ready,
    input logic [AW-1:0]  req_addr
);
    // R1
    lone_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_valid));

    // R4
    wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en && |(req_valid & req_ready) |-> bus_wait == !wait_pol);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en && |(req_valid & req_ready) |=>
        (!(sync_en && |req_valid) || req_addr == AW'($past(req_addr) + 1'b1)));

    // R7
    single_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en && req_valid[0] && req_ready[0] |=> (!sync_en || !req_valid[0]));

    // R7
    single_disk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en && req_valid[4] && req_ready[4] |=> (!sync_en || !req_valid[4]));

    // R8
    enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en && bus_ce_n[CE_BOOT] && bus_ce_n[CE_SHARED] && bus_ce_n[CE_DISK]
        |-> req_valid == '0);

    // R9
    async_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en && !bus_ce_n[CE_BOOT] |-> bus_wait == !wait_pol);
endmodule

bind hostbus_front hbf_checker #(
    .AW(AW), .NA(hbf_pkg::N_AREA), .NCE(NCE), .CE_BOOT(CE_BOOT),
    .CE_SHARED(CE_SHARED), .CE_DISK(CE_DISK)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .wait_pol(wait_pol),
    .bus_ce_n(bus_ce_n), .bus_wait(bus_wait), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr)
);

// File: tb/hostbus_front_tb_top.sv
`timescale 1ns/1ps
module hostbus_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sync_en, wait_pol;
    logic [25:0] cfg_bound_lo, cfg_bound_hi;
    logic [4:0]  bus_ce_n;
    logic        bus_adv_n, bus_oe_n, bus_we_n, bus_ub_n, bus_lb_n;
    logic [25:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        bus_wait;
    logic [4:0]  req_valid;
    logic        req_write;
    logic [25:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic [4:0]  req_ready;
    logic [79:0] area_rdata;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    // each area answers with its code+1 in the top nibble and the address below
    for (genvar a = 0; a < 5; a++) begin : g_mem
        assign area_rdata[a*16 +: 16] = {4'(a + 1), req_addr[11:0]};
    end

    hostbus_front dut_i (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .wait_pol(wait_pol),
        .cfg_bound_lo(cfg_bound_lo), .cfg_bound_hi(cfg_bound_hi),
        .bus_ce_n(bus_ce_n), .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_ub_n(bus_ub_n), .bus_lb_n(bus_lb_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .area_rdata(area_rdata)
    );

    task automatic check(string rq, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic wexp(bit active);
        return wait_pol ? active : !active;
    endfunction

    task automatic idle_bus();
        bus_ce_n = 5'b11111; bus_adv_n = 1; bus_oe_n = 1; bus_we_n = 1;
        bus_ub_n = 1; bus_lb_n = 1; req_ready = '1;
    endtask

    // tail: 0 = keep enable low (expect idle), 1 = release enable in a ready cycle
    task automatic sync_txn(int ce, int area, logic [25:0] base, bit wr,
                            int nbeats, int lat, bit stall, int tail, string rq);
        @(negedge clk);
        bus_ce_n = ~(5'b1 << ce); bus_adv_n = 0; bus_we_n = !wr; bus_oe_n = wr;
        bus_addr = base; bus_ub_n = 0; bus_lb_n = wr; bus_wdata = 16'h5A00 ^ base[15:0];
        req_ready = '1;
        #1 check(rq, "valid at strobe", req_valid, 0);
        check("R4", "wait at strobe", bus_wait, wexp(0));
        for (int k = 1; k < lat; k++) begin
            @(negedge clk);
            bus_adv_n = 1; bus_addr = 26'h3FF_FFFF;
            #1 check("R3", "valid during latency", req_valid, 0);
            check("R4", "wait during latency", bus_wait, wexp(1));
        end
        for (int b = 0; b < nbeats; b++) begin
            @(negedge clk);
            if (stall && b == 1) begin
                req_ready = '0;
                #1 check("R4", "valid in stall", req_valid, 5'b1 << area);
                check("R4", "wait in stall", bus_wait, wexp(1));
                check("R6", "addr held in stall", req_addr, base + b);
                @(negedge clk);
                req_ready = '1;
            end
            #1 check(rq, "valid in data", req_valid, 5'b1 << area);
            check("R4", "wait in ready cycle", bus_wait, wexp(0));
            check("R6", "beat address", req_addr, base + b);
            check("R3", "direction", req_write, wr);
            if (wr) check("R10", "byte enables", req_be, 2'b10);
            else    check("R3", "read data", bus_rdata,
                          {4'(area + 1), 12'(base + b)});
        end
        @(negedge clk);
        if (tail == 1) begin
            bus_ce_n = 5'b11111;
            #1 check("R8", "valid on release", req_valid, 0);
            check("R8", "wait on release", bus_wait, wexp(0));
            @(negedge clk);
            bus_ce_n = ~(5'b1 << ce);
            #1 check("R8", "no beat after release", req_valid, 0);
        end else begin
            #1 check(rq, "idle after last word", req_valid, 0);
            check("R4", "wait idle", bus_wait, wexp(0));
        end
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        rst_n = 0; sync_en = 1; wait_pol = 1;
        cfg_bound_lo = 26'h100; cfg_bound_hi = 26'h200;
        bus_addr = '0; bus_wdata = '0;
        idle_bus();
        repeat (3) @(negedge clk);
        #1 check("R11", "valid in reset", req_valid, 0);
        check("R11", "wait in reset", bus_wait, 0);
        @(negedge clk);
        rst_n = 1;
        cfg_bound_lo = 26'h0; cfg_bound_hi = 26'h0;   // must not reload (R2)
        #1 check("R11", "valid after reset", req_valid, 0);

        sync_txn(0, 0, 26'h040, 0, 1, 4, 0, 0, "R7");   // boot read
        sync_txn(0, 0, 26'h041, 1, 1, 3, 0, 0, "R7");   // boot write
        sync_txn(4, 4, 26'h007, 0, 1, 3, 0, 0, "R7");   // disk read
        sync_txn(4, 4, 26'h003, 1, 1, 3, 0, 0, "R1");   // disk write
        sync_txn(1, 1, 26'h080, 0, 4, 4, 1, 1, "R2");   // fast read burst
        sync_txn(1, 2, 26'h150, 1, 3, 7, 0, 1, "R2");   // slow write burst
        sync_txn(1, 3, 26'h250, 0, 32, 9, 0, 0, "R6");  // RAM max burst
        sync_txn(1, 2, 26'h1F0, 0, 2, 10, 1, 1, "R3");  // slow read
        sync_txn(1, 3, 26'h300, 1, 2, 6, 0, 1, "R3");   // RAM write
        sync_txn(1, 1, 26'h0FF, 1, 1, 3, 0, 1, "R2");   // fast write at bound
        wait_pol = 0;
        sync_txn(0, 0, 26'h123, 0, 1, 4, 0, 0, "R5");
        sync_txn(1, 3, 26'h2F0, 0, 3, 9, 1, 1, "R5");
        wait_pol = 1;

        // abort during latency (R8)
        @(negedge clk);
        bus_ce_n = 5'b11101; bus_adv_n = 0; bus_oe_n = 0; bus_addr = 26'h260;
        @(negedge clk); bus_adv_n = 1;
        @(negedge clk); bus_ce_n = 5'b11111;
        #1 check("R8", "wait after abort", bus_wait, wexp(0));
        @(negedge clk); bus_ce_n = 5'b11101;
        #1 check("R8", "idle after abort", bus_wait, wexp(0));
        check("R8", "valid after abort", req_valid, 0);
        repeat (12) begin
            @(negedge clk);
            #1 check("R8", "no late beat", req_valid, 0);
        end
        idle_bus();

        // asynchronous pass-through (R9, R1, R10)
        sync_en = 0;
        @(negedge clk);
        bus_ce_n = 5'b11110; bus_oe_n = 0; bus_addr = 26'h0AB; req_ready = '0;
        #1 check("R9", "async boot valid", req_valid, 5'b00001);
        check("R9", "async boot wait", bus_wait, wexp(0));
        check("R9", "async addr", req_addr, 26'h0AB);
        check("R9", "async rdata", bus_rdata, 16'h10AB);
        @(negedge clk);
        bus_ce_n = 5'b11101; bus_addr = 26'h250;
        #1 check("R9", "async RAM valid", req_valid, 5'b01000);
        check("R9", "async RAM wait not ready", bus_wait, wexp(1));
        req_ready = '1;
        #1 check("R9", "async RAM wait ready", bus_wait, wexp(0));
        @(negedge clk);
        bus_ce_n = 5'b11011;
        #1 check("R1", "held-high enable selects nothing", req_valid, 0);
        @(negedge clk);
        bus_ce_n = 5'b11100;
        #1 check("R1", "priority boot over shared", req_valid, 5'b00001);
        @(negedge clk);
        bus_ce_n = 5'b01111; bus_oe_n = 1; bus_we_n = 0; bus_ub_n = 1; bus_lb_n = 0;
        bus_wdata = 16'hBEEF;
        #1 check("R10", "async disk valid", req_valid, 5'b10000);
        check("R10", "async write flag", req_write, 1);
        check("R10", "lower byte only", req_be, 2'b01);
        check("R10", "write data", req_wdata, 16'hBEEF);
        @(negedge clk);
        idle_bus();
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule